// File: doc/BRIEF.md
# I2C Target Read-Data Transmitter with Clock Stretching

This block is the transmit half of an I2C target. Once an address decoder elsewhere has recognised the target's own address with the read bit set, it pulses a "selected for read" input. The block then acknowledges the address on the ninth clock. After that acknowledge it holds SCL low, so the master cannot clock data out before the local host is ready.

The host supplies one byte through a write strobe and then pulses a release control. Only then is SCL let go. The byte is shifted out most significant bit first, and SDA only ever moves while SCL is low. On the ninth clock the block floats SDA and samples the master's acknowledge on the rising SCL edge. On the falling edge of that clock it pulses an event to the host, whether the master acknowledged or not. An acknowledge makes the block stretch SCL again for the next byte. A not-acknowledge returns it to idle, where it waits for the next selection after a START or STOP.

Both bus lines are open-drain. The block only produces drive-low enables and never drives a high level. SCL and SDA arrive already synchronised to the block clock.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset both drive-low enables and the event output are 0.
- R2: A pulse on `rd_sel_i` while idle and while SCL is high makes `sda_oe_o` 1 from the next SCL falling edge until the following SCL falling edge (the address ACK). The same pulse is ignored outside the idle state.
- R3: At the SCL falling edge that ends the address ACK, `scl_oe_o` becomes 1 and `sda_oe_o` becomes 0. SCL then stays held low even after the master releases it.
- R4: A pulse on `scl_rel_i` while SCL is held but before any byte has been written has no effect: `scl_oe_o` stays 1. A release after a write clears `scl_oe_o`.
- R5: `tx_wr_i` loads `tx_data_i` only while SCL is being held. A write during a byte shift does not alter the bits being sent.
- R6: The byte is sent MSB first, as DATA_W bits, with `sda_oe_o` = 1 for a 0 bit. `sda_oe_o` never changes while SCL is high. The first bit is presented as soon as the byte is written.
- R7: During the ninth clock of each byte `sda_oe_o` is 0. The master's SDA level is captured on the rising SCL edge of that clock.
- R8: `evt_o` is a one-cycle pulse in the cycle after the ninth SCL falling edge of every transmitted byte, for both ACK and NACK.
- R9: If the master acknowledged (SDA low), `scl_oe_o` is 1 again after that falling edge, with no byte loaded. If it did not acknowledge, both enables are 0 and a new `rd_sel_i` is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| rd_sel_i | input | 1 | Pulse: own address matched with the read bit set |
| tx_wr_i | input | 1 | Host write strobe for the transmit byte |
| tx_data_i | input | DATA_W | Transmit byte from the host |
| scl_rel_i | input | 1 | Host pulse that releases a held SCL |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| scl_oe_o | output | 1 | Drive SCL low when 1 |
| evt_o | output | 1 | One-cycle event after each byte's ninth clock |

## Verification
The bench builds the block with the default DATA_W of 8. This makes MSB-first ordering and the eighth-bit hand-over into the acknowledge slot visible on real byte values such as 0xA5, 0x3C, 0x01 and 0x80. The bench acts as an open-drain master that honours clock stretching. With that width it covers both acknowledge outcomes, a release issued before any data, a write injected mid-byte, and a selection pulse issued while the clock is already held.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_WAIT,
    ST_ADDR_ACK,
    ST_STRETCH,
    ST_SHIFT,
    ST_ACKSLOT
  } stx_state_e;

  // open-drain: a 0 data bit pulls the line, a 1 bit floats it
  function automatic logic f_pull_for(input logic data_bit);
    return ~data_bit;
  endfunction

  // true when the counter points at the final bit of a DATA_W-wide byte
  function automatic logic f_is_last(input int unsigned idx, input int unsigned width);
    return idx == width - 1;
  endfunction

endpackage

// File: rtl/i2c_stx_edge.sv
module i2c_stx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);

  logic line_q;

  // bus idles high, so the history starts at 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_i;
  end

  assign rise_o = line_i & ~line_q;
  assign fall_o = ~line_i & line_q;

endmodule

// File: rtl/i2c_stx_shreg.sv
module i2c_stx_shreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o
);

  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[DATA_W-1];

endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_stx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              rd_sel_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              scl_rel_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              evt_o
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  // named internal events
  logic scl_rise, scl_fall;
  logic last_bit, load_ok, go_shift, shift_en, ack_fall, ack_sample;
  logic tx_msb;

  stx_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             full_q;
  logic             mack_q;
  logic             evt_q;

  i2c_stx_edge u_scl_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (scl_i),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  assign last_bit   = f_is_last(int'(cnt_q), DATA_W);
  assign load_ok    = (state_q == ST_STRETCH) && tx_wr_i;
  assign go_shift   = (state_q == ST_STRETCH) && full_q && scl_rel_i;
  assign shift_en   = (state_q == ST_SHIFT) && scl_fall && !last_bit;
  assign ack_sample = (state_q == ST_ACKSLOT) && scl_rise;
  assign ack_fall   = (state_q == ST_ACKSLOT) && scl_fall;

  i2c_stx_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_ok),
    .data_i  (tx_data_i),
    .shift_i (shift_en),
    .msb_o   (tx_msb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (rd_sel_i && scl_i)     state_d = ST_ADDR_WAIT;
      ST_ADDR_WAIT: if (scl_fall)              state_d = ST_ADDR_ACK;
      ST_ADDR_ACK:  if (scl_fall)              state_d = ST_STRETCH;
      ST_STRETCH:   if (go_shift)              state_d = ST_SHIFT;
      ST_SHIFT:     if (scl_fall && last_bit)  state_d = ST_ACKSLOT;
      ST_ACKSLOT:   if (scl_fall)              state_d = mack_q ? ST_STRETCH : ST_IDLE;
      default:                                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      mack_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= ack_fall;
      if (go_shift)      cnt_q <= '0;
      else if (shift_en) cnt_q <= cnt_q + 1'b1;
      if (go_shift || state_q == ST_IDLE) full_q <= 1'b0;
      else if (load_ok)                   full_q <= 1'b1;
      if (ack_sample) mack_q <= ~sda_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK: sda_oe_o = 1'b1;
      ST_SHIFT:    sda_oe_o = f_pull_for(tx_msb);
      ST_STRETCH:  sda_oe_o = full_q & f_pull_for(tx_msb);
      default:     sda_oe_o = 1'b0;
    endcase
  end

  assign scl_oe_o = (state_q == ST_STRETCH);
  assign evt_o    = evt_q;

  // R6: data line never moves while SCL stays high
  a_r6_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R3: clock held right after the address acknowledge ends
  a_r3_hold_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q == ST_ADDR_ACK) && $past(scl_fall)) |-> scl_oe_o);

  // R4: a held clock is only let go after a byte and a release
  a_r4_release_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe_o) |-> ($past(full_q) && $past(scl_rel_i)));

  // R8: event follows a falling SCL edge and lasts one cycle
  a_r8_evt_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(scl_fall));
  a_r8_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

  // R7: data line left free when the acknowledge clock finishes
  a_r7_sda_free_at_evt: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> !sda_oe_o);

  // R9: master ACK brings back clock stretching
  a_r9_ack_restretch: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && mack_q) |-> scl_oe_o);

endmodule

// File: tb/i2c_slave_tx_tb.sv
module i2c_slave_tx_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_sel = 1'b0, tx_wr = 1'b0, scl_rel = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic sda_oe, scl_oe, evt;
  logic scl_line, sda_line;

  int tests = 0, fails = 0, evt_cnt = 0, evt_exp = 0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_slave_tx #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .rd_sel_i(rd_sel), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .scl_rel_i(scl_rel),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .evt_o(evt)
  );

  always @(posedge clk) if (evt) evt_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic rel_scl_wait();
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic pulse_rdsel();
    @(negedge clk) rd_sel = 1'b1;
    @(negedge clk) rd_sel = 1'b0;
  endtask

  task automatic pulse_rel();
    @(negedge clk) scl_rel = 1'b1;
    @(negedge clk) scl_rel = 1'b0;
  endtask

  // driver: host write, expected byte goes to the scoreboard when push is set
  task automatic host_write(input logic [W-1:0] d, input bit push);
    @(negedge clk) begin tx_wr = 1'b1; tx_data = d; end
    @(negedge clk) tx_wr = 1'b0;
    if (push) exp_q.push_back(d);
  endtask

  // master side of the address phase: SCL is high in the 8th clock
  task automatic address_phase();
    pulse_rdsel();
    half();
    m_scl_low = 1'b1;  // 8th falling edge
    half();
    chk("R2 address ACK driven", sda_oe, 1);
    rel_scl_wait(); half();
    chk("R2 ACK held while SCL high", sda_oe, 1);
    half();
    m_scl_low = 1'b1;  // 9th falling edge
    half();
    chk("R3 SCL held after address ACK", scl_oe, 1);
    chk("R3 SDA released after address ACK", sda_oe, 0);
    m_scl_low = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 SCL line still low", scl_line, 0);
  endtask

  // monitor: clocks a byte out, pops the scoreboard and compares
  task automatic read_byte(input bit ack, input bit inject);
    logic [W-1:0] got, exp;
    logic s1, s2;
    got = '0;
    for (int i = 0; i < W; i++) begin
      rel_scl_wait();
      half();
      s1 = sda_line;
      if (inject && i == 3) host_write(8'hFF, 1'b0);  // R5: ignored mid-shift
      half();
      s2 = sda_line;
      chk("R6 SDA stable while SCL high", s2, s1);
      got = {got[W-2:0], s1};
      m_scl_low = 1'b1;
      half();
    end
    chk("R7 SDA released in ninth clock", sda_oe, 0);
    m_sda_low = ack;
    half();
    rel_scl_wait();
    half(); half();
    m_scl_low = 1'b1;  // ninth falling edge
    half();
    m_sda_low = 1'b0;
    evt_exp++;
    chk("R8 event once per byte", evt_cnt, evt_exp);
    exp = exp_q.pop_front();
    chk(inject ? "R5 byte unchanged by mid-shift write" : "R6 byte MSB first", got, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 scl_oe after reset", scl_oe, 0);
    chk("R1 evt after reset", evt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // transaction 1: ACK then NACK
    address_phase();
    pulse_rdsel();
    repeat (4) @(negedge clk);
    chk("R2 rd_sel ignored while held: scl", scl_oe, 1);
    chk("R2 rd_sel ignored while held: sda", sda_oe, 0);
    pulse_rel();
    repeat (4) @(negedge clk);
    chk("R4 release without byte ignored", scl_oe, 1);
    host_write(8'hA5, 1'b1);
    chk("R6 first bit presented on write", sda_oe, 0);
    pulse_rel();
    chk("R4 release after write frees SCL", scl_oe, 0);
    read_byte(1'b1, 1'b1);
    chk("R9 ACK re-stretches SCL", scl_oe, 1);
    m_scl_low = 1'b0;
    pulse_rel();
    repeat (4) @(negedge clk);
    chk("R9 no byte loaded after ACK", scl_oe, 1);
    host_write(8'h3C, 1'b1);
    chk("R6 first bit of 0x3C", sda_oe, 1);
    pulse_rel();
    read_byte(1'b0, 1'b0);
    chk("R9 NACK frees SCL", scl_oe, 0);
    chk("R9 NACK frees SDA", sda_oe, 0);
    m_scl_low = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 no extra event", evt_cnt, evt_exp);
    host_write(8'h00, 1'b0);
    pulse_rel();
    repeat (4) @(negedge clk);
    chk("R9 idle ignores host after NACK", sda_oe | scl_oe, 0);

    // transaction 2: 0x01 with ACK, 0x80 with NACK
    address_phase();
    host_write(8'h01, 1'b1);
    pulse_rel();
    read_byte(1'b1, 1'b0);
    chk("R9 ACK re-stretch second transfer", scl_oe, 1);
    m_scl_low = 1'b0;
    host_write(8'h80, 1'b1);
    pulse_rel();
    read_byte(1'b0, 1'b0);
    chk("R9 NACK ends second transfer", scl_oe, 0);
    m_scl_low = 1'b0;
    repeat (10) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule